// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a parallel RGB panel. A divided clock enable paces a horizontal position counter. Each wrap of that counter advances a vertical line counter. From the two counters the block derives horizontal sync, vertical sync, data-enable and a line-match flag. Software sets up the block through a write-only register bus: the sync width, back porch, active size and front porch for each direction, a clock divisor, a line threshold and a control word. A frame interrupt can be raised either on the leading edge of vertical sync or on the leading edge of the line match. Software clears it by writing a one.

In each direction the raster is handled by the same segment state machine. Its states are `SEG_SYNC`, `SEG_BACK`, `SEG_ACTIVE` and `SEG_FRONT`, always visited in that order. A step taken on the last count of a segment moves it to the next state, and the step out of `SEG_FRONT` returns it to `SEG_SYNC` (the wrap). When the scan is not running, the machine is forced to `SEG_SYNC`. A run state machine has two states, `RUN_IDLE` and `RUN_SCAN`. It moves from `RUN_IDLE` to `RUN_SCAN` on the clock edge after the video-enable bit is seen set, and back to `RUN_IDLE` on the edge after it is seen clear. While it is in `RUN_IDLE`, the counters and the divider are held at zero and every timing output is inactive.

Register map (address on `bus_addr`): 0 control, 1 horizontal sync, 2 horizontal back porch, 3 horizontal front porch, 4 vertical sync, 5 vertical back porch, 6 vertical front porch, 7 active size, 8 clock divisor, 9 line threshold, 10 interrupt status. Registers take effect on the clock edge where `bus_we` is high.

Top module: `vtg_top`

## Requirements
- R1: After reset, and whenever control bit 0 (video enable) is clear, hsync, vsync, de and line_match are low and pix_cnt and line_cnt read 0. Programming the timing registers while disabled changes none of these.
- R2: Registers 1, 2 and 3 hold (pixels - 1) in bits [11:0]. Every line runs hsync, then back porch, then active, then front porch, and hsync is high for pixel positions 0 up to the sync width minus 1.
- R3: Registers 4, 5 and 6 hold (lines - 1) in bits [11:0]. Every frame runs vsync, then back porch, then active, then front porch, and vsync is high for line positions 0 up to the sync height minus 1.
- R4: Register 7 holds (active width - 1) in bits [11:0] and (active height - 1) in bits [27:16], so a frame carries exactly width × height cycles of de when each pixel lasts one clock.
- R5: de is high only when both the pixel position and the line position lie inside their active segments.
- R6: After the last front-porch pixel, pix_cnt returns to 0 and line_cnt advances. After the last front-porch pixel of the last front-porch line, both return to 0.
- R7: Register 8 bits [7:0] hold F, and the pixel position advances once every min(F+1, 255) clocks. F = 255 therefore saturates at 255.
- R8: Register 9 bits [13:0] hold a line threshold, and line_match is high for the whole line whose line_cnt equals it.
- R9: Control bit 2 selects the interrupt source: 1 for the leading edge of vsync, 0 for the leading edge of line_match. With control bit 1 (interrupt enable) set, irq goes high on the clock after the selected edge.
- R10: Writing 1 to bit 0 of register 10 clears irq on that edge, and writing 0 there leaves it unchanged. If a new event arrives on the same edge as a clear, the event wins.
- R11: With the interrupt enable clear, no event sets irq, and an irq that is already set stays set until it is cleared.
- R12: Clearing video enable returns the outputs to idle on the second edge after the write. Setting it again restarts the scan at pixel 0, line 0, inside hsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-video data enable |
| pix_cnt | output | 14 | Pixel position within the line |
| line_cnt | output | 14 | Line position within the frame |
| line_match | output | 1 | Line counter equals threshold |
| irq | output | 1 | Frame interrupt status |

## Verification
The assertions assume that the segment and divisor registers stay fixed while the scan runs, because the hold and wrap properties assume a steady raster. The stimulus respects this by writing timing and divisor registers only while video enable is clear; while scanning it writes only control and status. The line threshold is kept below the programmed frame height so that the line-match source actually produces edges. Status clears are issued back to back for a long stretch so that some of them land on the same edge as a frame event.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC,
        SEG_BACK,
        SEG_ACTIVE,
        SEG_FRONT
    } seg_e;

    typedef enum logic {
        RUN_IDLE,
        RUN_SCAN
    } run_e;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_HSYNC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_HBACK  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HFRONT = 4'd3;
    localparam logic [ADDR_W-1:0] A_VSYNC  = 4'd4;
    localparam logic [ADDR_W-1:0] A_VBACK  = 4'd5;
    localparam logic [ADDR_W-1:0] A_VFRONT = 4'd6;
    localparam logic [ADDR_W-1:0] A_SIZE   = 4'd7;
    localparam logic [ADDR_W-1:0] A_DIV    = 4'd8;
    localparam logic [ADDR_W-1:0] A_THR    = 4'd9;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd10;

    localparam int unsigned SIZE_H_LSB = 16;

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int unsigned CW   = 12,
    parameter int unsigned PW   = 14,
    parameter int unsigned DIVW = 8,
    parameter int unsigned DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              frame_evt,
    output logic              video_en,
    output logic              irq_en,
    output logic              src_vsync,
    output logic [CW-1:0]     hs_m1,
    output logic [CW-1:0]     hb_m1,
    output logic [CW-1:0]     ha_m1,
    output logic [CW-1:0]     hf_m1,
    output logic [CW-1:0]     vs_m1,
    output logic [CW-1:0]     vb_m1,
    output logic [CW-1:0]     va_m1,
    output logic [CW-1:0]     vf_m1,
    output logic [DIVW-1:0]   div_m1,
    output logic [PW-1:0]     line_thr,
    output logic              status
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata;

    logic clr_hit;
    assign clr_hit = we && (addr == A_STATUS) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            video_en  <= 1'b0;
            irq_en    <= 1'b0;
            src_vsync <= 1'b0;
            hs_m1     <= '0;
            hb_m1     <= '0;
            ha_m1     <= '0;
            hf_m1     <= '0;
            vs_m1     <= '0;
            vb_m1     <= '0;
            va_m1     <= '0;
            vf_m1     <= '0;
            div_m1    <= '0;
            line_thr  <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    video_en  <= wdata[0];
                    irq_en    <= wdata[1];
                    src_vsync <= wdata[2];
                end
                A_HSYNC:  hs_m1    <= wdata[CW-1:0];
                A_HBACK:  hb_m1    <= wdata[CW-1:0];
                A_HFRONT: hf_m1    <= wdata[CW-1:0];
                A_VSYNC:  vs_m1    <= wdata[CW-1:0];
                A_VBACK:  vb_m1    <= wdata[CW-1:0];
                A_VFRONT: vf_m1    <= wdata[CW-1:0];
                A_SIZE: begin
                    ha_m1 <= wdata[CW-1:0];
                    va_m1 <= wdata[SIZE_H_LSB +: CW];
                end
                A_DIV:    div_m1   <= wdata[DIVW-1:0];
                A_THR:    line_thr <= wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    // Event set has priority over a clear arriving on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (frame_evt && irq_en) begin
            status <= 1'b1;
        end else if (clr_hit) begin
            status <= 1'b0;
        end
    end

endmodule

// File: rtl/vtg_clkdiv.sv
module vtg_clkdiv #(
    parameter int unsigned DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_m1,
    output logic            pix_en
);

    // Largest divisor is 2**DIVW - 1; an all-ones field saturates there.
    localparam logic [DIVW-1:0] SAT_M1 = DIVW'((2 ** DIVW) - 2);

    logic [DIVW-1:0] lim_m1;
    logic [DIVW-1:0] cnt_q;

    assign lim_m1 = (&div_m1) ? SAT_M1 : div_m1;
    assign pix_en = run && (cnt_q >= lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || pix_en) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int unsigned CW = 12,
    parameter int unsigned PW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] sync_m1,
    input  logic [CW-1:0] back_m1,
    input  logic [CW-1:0] act_m1,
    input  logic [CW-1:0] front_m1,
    output logic [PW-1:0] pos,
    output logic          in_sync,
    output logic          in_active,
    output logic          wrap
);

    seg_e          seg_q, seg_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] pos_q, pos_d;
    logic [CW-1:0] seg_len_m1;
    logic          last_in_seg;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
            pos_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
            pos_q <= pos_d;
        end
    end

    always_comb begin
        seg_len_m1 = sync_m1;
        unique case (seg_q)
            SEG_SYNC:   seg_len_m1 = sync_m1;
            SEG_BACK:   seg_len_m1 = back_m1;
            SEG_ACTIVE: seg_len_m1 = act_m1;
            SEG_FRONT:  seg_len_m1 = front_m1;
        endcase
    end

    assign last_in_seg = (cnt_q == seg_len_m1);
    assign wrap        = run && step && last_in_seg && (seg_q == SEG_FRONT);

    // Next-state logic
    always_comb begin
        seg_d = seg_q;
        cnt_d = cnt_q;
        pos_d = pos_q;
        if (!run) begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
            pos_d = '0;
        end else if (step) begin
            if (last_in_seg) begin
                cnt_d = '0;
                pos_d = pos_q + 1'b1;
                unique case (seg_q)
                    SEG_SYNC:   seg_d = SEG_BACK;
                    SEG_BACK:   seg_d = SEG_ACTIVE;
                    SEG_ACTIVE: seg_d = SEG_FRONT;
                    SEG_FRONT: begin
                        seg_d = SEG_SYNC;
                        pos_d = '0;
                    end
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
                pos_d = pos_q + 1'b1;
            end
        end
    end

    // Output logic
    always_comb begin
        in_sync   = 1'b0;
        in_active = 1'b0;
        unique case (seg_q)
            SEG_SYNC:   in_sync   = 1'b1;
            SEG_BACK:   ;
            SEG_ACTIVE: in_active = 1'b1;
            SEG_FRONT:  ;
        endcase
    end

    assign pos = pos_q;

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int unsigned CW   = 12,
    parameter int unsigned DIVW = 8,
    parameter int unsigned DW   = 32,
    localparam int unsigned PW  = CW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PW-1:0]     pix_cnt,
    output logic [PW-1:0]     line_cnt,
    output logic              line_match,
    output logic              irq
);

    logic            video_en, irq_en, src_vsync, status;
    logic [CW-1:0]   hs_m1, hb_m1, ha_m1, hf_m1;
    logic [CW-1:0]   vs_m1, vb_m1, va_m1, vf_m1;
    logic [DIVW-1:0] div_m1;
    logic [PW-1:0]   line_thr;
    logic            frame_evt;
    logic            pix_en;
    logic            run;
    logic [PW-1:0]   h_pos, v_pos;
    logic            h_sync, h_act, h_wrap;
    logic            v_sync, v_act, v_wrap;
    logic            vs_q, lm_q;
    run_e            run_q, run_d;

    vtg_regs #(.CW(CW), .PW(PW), .DIVW(DIVW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .frame_evt (frame_evt),
        .video_en  (video_en),
        .irq_en    (irq_en),
        .src_vsync (src_vsync),
        .hs_m1     (hs_m1),
        .hb_m1     (hb_m1),
        .ha_m1     (ha_m1),
        .hf_m1     (hf_m1),
        .vs_m1     (vs_m1),
        .vb_m1     (vb_m1),
        .va_m1     (va_m1),
        .vf_m1     (vf_m1),
        .div_m1    (div_m1),
        .line_thr  (line_thr),
        .status    (status)
    );

    // Run state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_IDLE;
        end else begin
            run_q <= run_d;
        end
    end

    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_IDLE: if (video_en)  run_d = RUN_SCAN;
            RUN_SCAN: if (!video_en) run_d = RUN_IDLE;
        endcase
    end

    always_comb begin
        run = 1'b0;
        unique case (run_q)
            RUN_IDLE: run = 1'b0;
            RUN_SCAN: run = 1'b1;
        endcase
    end

    vtg_clkdiv #(.DIVW(DIVW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_m1 (div_m1),
        .pix_en (pix_en)
    );

    vtg_axis #(.CW(CW), .PW(PW)) u_hor (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (pix_en),
        .sync_m1   (hs_m1),
        .back_m1   (hb_m1),
        .act_m1    (ha_m1),
        .front_m1  (hf_m1),
        .pos       (h_pos),
        .in_sync   (h_sync),
        .in_active (h_act),
        .wrap      (h_wrap)
    );

    vtg_axis #(.CW(CW), .PW(PW)) u_ver (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (h_wrap),
        .sync_m1   (vs_m1),
        .back_m1   (vb_m1),
        .act_m1    (va_m1),
        .front_m1  (vf_m1),
        .pos       (v_pos),
        .in_sync   (v_sync),
        .in_active (v_act),
        .wrap      (v_wrap)
    );

    assign hsync      = run && h_sync;
    assign vsync      = run && v_sync;
    assign de         = run && h_act && v_act;
    assign pix_cnt    = run ? h_pos : '0;
    assign line_cnt   = run ? v_pos : '0;
    assign line_match = run && (v_pos == line_thr);
    assign irq        = status;

    // Edge detectors for the two interrupt sources
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
            lm_q <= 1'b0;
        end else begin
            vs_q <= vsync;
            lm_q <= line_match;
        end
    end

    assign frame_evt = src_vsync ? (vsync && !vs_q) : (line_match && !lm_q);

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int unsigned PW   = 14,
    parameter int unsigned DIVW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            pix_en,
    input logic            v_wrap,
    input logic            irq_en,
    input logic [DIVW-1:0] div_m1,
    input logic            hsync,
    input logic            vsync,
    input logic            de,
    input logic [PW-1:0]   pix_cnt,
    input logic [PW-1:0]   line_cnt,
    input logic            irq
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!hsync && !vsync && !de && pix_cnt == '0 && line_cnt == '0));

    a_r5_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));

    a_r7_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(pix_en)) |-> $stable(pix_cnt));

    a_r7_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && div_m1 != '0) |=> (!pix_en || div_m1 == '0));

    a_r6_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && pix_cnt != '0) |-> $stable(line_cnt));

    a_r6_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |=> (pix_cnt == '0 && line_cnt == '0));

    a_r11_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));

endmodule

bind vtg_top vtg_checker #(.PW(PW), .DIVW(DIVW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pix_en   (pix_en),
    .v_wrap   (v_wrap),
    .irq_en   (irq_en),
    .div_m1   (div_m1),
    .hsync    (hsync),
    .vsync    (vsync),
    .de       (de),
    .pix_cnt  (pix_cnt),
    .line_cnt (line_cnt),
    .irq      (irq)
);

// File: tb/vtg_top_bench.sv
`timescale 1ns/1ps
module vtg_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        hsync, vsync, de, line_match, irq;
    logic [13:0] pix_cnt, line_cnt;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    vtg_top u_vtg_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .hsync      (hsync),
        .vsync      (vsync),
        .de         (de),
        .pix_cnt    (pix_cnt),
        .line_cnt   (line_cnt),
        .line_match (line_match),
        .irq        (irq)
    );

    // Shadow of programmed settings, as lengths
    bit sh_en = 0, sh_ien = 0, sh_src = 0;
    int hsl = 1, hbl = 1, hal = 1, hfl = 1;
    int vsl = 1, vbl = 1, val = 1, vfl = 1;
    int sh_div = 0, sh_thr = 0;

    // Reference raster state
    bit m_run = 0, m_status = 0, m_vsq = 0, m_lmq = 0;
    int m_pix = 0, m_line = 0, m_div = 0;

    task automatic fail(string tag, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) fail(tag, what, act, exp);
    endtask

    always @(posedge clk) begin : model
        bit vs_now, lm_now, ev;
        int n, htot, vtot;
        if (!rst_n) begin
            sh_en = 0; sh_ien = 0; sh_src = 0;
            hsl = 1; hbl = 1; hal = 1; hfl = 1;
            vsl = 1; vbl = 1; val = 1; vfl = 1;
            sh_div = 0; sh_thr = 0;
            m_run = 0; m_status = 0; m_vsq = 0; m_lmq = 0;
            m_pix = 0; m_line = 0; m_div = 0;
        end else begin
            htot = hsl + hbl + hal + hfl;
            vtot = vsl + vbl + val + vfl;
            vs_now = m_run && (m_line < vsl);
            lm_now = m_run && (m_line == sh_thr);
            ev = sh_src ? (vs_now && !m_vsq) : (lm_now && !m_lmq);
            m_status = (ev && sh_ien) ||
                       (m_status && !(bus_we && bus_addr == 4'd10 && bus_wdata[0]));
            m_vsq = vs_now;
            m_lmq = lm_now;
            n = (sh_div == 255) ? 255 : sh_div + 1;
            if (m_run) begin
                if (m_div >= n - 1) begin
                    m_div = 0;
                    if (m_pix == htot - 1) begin
                        m_pix = 0;
                        m_line = (m_line == vtot - 1) ? 0 : m_line + 1;
                    end else begin
                        m_pix++;
                    end
                end else begin
                    m_div++;
                end
            end else begin
                m_div = 0; m_pix = 0; m_line = 0;
            end
            m_run = sh_en;
            if (bus_we) begin
                case (bus_addr)
                    4'd0: begin sh_en = bus_wdata[0]; sh_ien = bus_wdata[1]; sh_src = bus_wdata[2]; end
                    4'd1: hsl = int'(bus_wdata[11:0]) + 1;
                    4'd2: hbl = int'(bus_wdata[11:0]) + 1;
                    4'd3: hfl = int'(bus_wdata[11:0]) + 1;
                    4'd4: vsl = int'(bus_wdata[11:0]) + 1;
                    4'd5: vbl = int'(bus_wdata[11:0]) + 1;
                    4'd6: vfl = int'(bus_wdata[11:0]) + 1;
                    4'd7: begin hal = int'(bus_wdata[11:0]) + 1; val = int'(bus_wdata[27:16]) + 1; end
                    4'd8: sh_div = int'(bus_wdata[7:0]);
                    4'd9: sh_thr = int'(bus_wdata[13:0]);
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin : compare
        bit e_hs, e_vs, e_de, e_lm;
        int e_pix, e_line;
        if (rst_n && cmp_on) begin
            e_hs   = m_run && (m_pix < hsl);
            e_vs   = m_run && (m_line < vsl);
            e_de   = m_run && (m_pix >= hsl + hbl) && (m_pix < hsl + hbl + hal) &&
                     (m_line >= vsl + vbl) && (m_line < vsl + vbl + val);
            e_lm   = m_run && (m_line == sh_thr);
            e_pix  = m_run ? m_pix : 0;
            e_line = m_run ? m_line : 0;
            checks++;
            if (hsync !== e_hs)        fail("R2", "hsync", int'(hsync), int'(e_hs));
            if (vsync !== e_vs)        fail("R3", "vsync", int'(vsync), int'(e_vs));
            if (de !== e_de)           fail("R4/R5", "de", int'(de), int'(e_de));
            if (int'(pix_cnt) != e_pix)  fail("R6/R7", "pix_cnt", int'(pix_cnt), e_pix);
            if (int'(line_cnt) != e_line) fail("R6", "line_cnt", int'(line_cnt), e_line);
            if (line_match !== e_lm)   fail("R8", "line_match", int'(line_match), int'(e_lm));
            if (irq !== m_status)      fail("R9/R10", "irq", int'(irq), int'(m_status));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        bus_we    = 1'b1;
        bus_addr  = 4'(a);
        bus_wdata = 32'(d);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(string tag);
        int k = 0;
        while (irq !== 1'b1 && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(tag, "irq arrives", int'(irq), 1);
    endtask

    initial begin
        int de_cnt;
        int pulses;
        int gap;
        int prev;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "hsync after reset", int'(hsync), 0);
        chk("R1", "de after reset", int'(de), 0);
        chk("R1", "line_cnt after reset", int'(line_cnt), 0);

        // Raster: h 2/3/4/2 = 11, v 1/2/3/2 = 8
        wr(1, 1); wr(2, 2); wr(3, 1);
        wr(7, (2 << 16) | 3);
        wr(4, 0); wr(5, 1); wr(6, 1);
        wr(8, 0); wr(9, 2);
        idle(3);
        chk("R1", "hsync while disabled", int'(hsync), 0);
        chk("R1", "pix_cnt while disabled", int'(pix_cnt), 0);

        // R9: vsync source, interrupt enabled
        wr(0, 7);
        @(negedge clk);
        // R4: count de over one full frame from its first cycle
        chk("R2", "hsync at frame start", int'(hsync), 1);
        de_cnt = 0;
        for (int i = 0; i < 88; i++) begin
            if (de) de_cnt++;
            @(negedge clk);
        end
        chk("R4", "de cycles per frame", de_cnt, 12);
        idle(150);

        // R10: write 0 keeps, write 1 clears
        wait_irq("R9");
        wr(10, 0);
        chk("R10", "irq after writing 0", int'(irq), 1);
        wr(10, 1);
        chk("R10", "irq after writing 1", int'(irq), 0);

        // R10: continuous clears, events must still win
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            wr(10, 1);
            if (irq) pulses++;
        end
        chk("R10", "set beats clear pulses", int'(pulses >= 2), 1);

        // R11: enable off keeps pending status, blocks new ones
        wait_irq("R11");
        wr(0, 5);
        idle(100);
        chk("R11", "pending irq kept", int'(irq), 1);
        wr(10, 1);
        idle(200);
        chk("R11", "no irq while disabled", int'(irq), 0);

        // R8/R9: line-match source
        wr(9, 5);
        wr(0, 3);
        wait_irq("R9");
        chk("R9", "line at line-match irq", int'(line_cnt), 5);
        chk("R8", "line_match at irq", int'(line_match), 1);
        wr(10, 1);
        idle(100);

        // R12: stop and restart
        wr(0, 0);
        @(negedge clk);
        chk("R12", "hsync after stop", int'(hsync), 0);
        chk("R12", "pix_cnt after stop", int'(pix_cnt), 0);
        chk("R12", "line_cnt after stop", int'(line_cnt), 0);
        idle(5);
        wr(0, 1);
        @(negedge clk);
        chk("R12", "hsync on restart", int'(hsync), 1);
        chk("R12", "pix_cnt on restart", int'(pix_cnt), 0);
        idle(50);

        // R7: divisor 3
        wr(0, 0); wr(8, 2); wr(0, 1);
        idle(300);

        // R7: saturated divisor
        wr(0, 0); wr(8, 255); wr(0, 1);
        prev = int'(pix_cnt);
        while (int'(pix_cnt) == prev) @(negedge clk);
        prev = int'(pix_cnt);
        gap = 0;
        while (int'(pix_cnt) == prev && gap < 1000) begin
            @(negedge clk);
            gap++;
        end
        chk("R7", "saturated pixel period", gap, 255);
        wr(0, 0);
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule